// File: doc/BRIEF.md
# Platform status and control register window

This block occupies a 4 KiB slot on a simple single-cycle read/write bus and reports the board's fixed configuration to software. It gives software a memory status word, a clock-divider description, a build-configuration word and a memory-configuration word. The clock and memory words are built from two parameters: the timer input frequency in MHz and the memory size in GiB. Every other readable location, the identifier words among them, reads as zero.

Only complete 32-bit accesses count. Any request whose byte count is not exactly four reads back as zero and writes nothing. All writes are discarded, with one exception. A full-word write to the soft-reset control location with bit 4 set produces a one-cycle, clock-registered request to the chip's reset controller. That controller is outside this block.

Requests are sampled on the rising clock edge while `req_valid` is high. Read data is registered and appears in the cycle after the read request. It then holds until the next read.

Top module: `plat_status_regs`

## Requirements
- R1: A request whose `req_bytes` is not 4 has no effect: a read returns 0x00000000 and a write raises no reset request.
- R2: Full-word reads of offsets 0x000, 0x004 and 0x008 return 0x00000000.
- R3: A full-word read of offset 0x014 returns 0x00000005 (bit 0 locked, bit 2 calibrated).
- R4: A full-word read of offset 0x030 returns 1 in bits 31:24, 1 in bits 23:16, TIMER_MHZ in bits 15:8 and 1 in bits 7:0.
- R5: A full-word read of offset 0x034 returns 0x0000000E (bits 1, 2 and 3 set, bit 0 clear).
- R6: A full-word read of offset 0x038 returns MEM_GIB in bits 3:0, 0xFFF in bits 15:4 and zero above.
- R7: A full-word write to offset 0x010 with write-data bit 4 set drives `sys_reset_req` high for exactly the one cycle after the write. A write there with bit 4 clear does not pulse it.
- R8: Writes to the read-only offsets 0x000 to 0x008, 0x014, 0x018, 0x030, 0x034 and 0x038 change no later read value and raise no reset request.
- R9: Reads of every other offset return 0x00000000, including 0x010, 0x018 and any address not a multiple of four. Writes to those offsets are ignored and produce no error indication.
- R10: `rdata` is 0 after reset. It changes only on the clock edge that samples a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (12) | Byte offset within the window |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps every byte address of the window with a full-word read. This catches decoders that ignore the low two address bits: such a decoder would alias unaligned addresses onto the status words. Each word offset is also read at sizes 0, 1, 2, 3, 5 and 8. A design that decodes only the offset would return register data for partial accesses.

Every aligned offset is then written with all ones and the whole window is read again. A register that kept write data would show up there, and so would a reset request raised by the wrong offset or by a cleared trigger bit. The pulse is checked in the cycle after the write and in the cycle after that. A level output or an unregistered pulse would appear one cycle early or stay high.

// File: rtl/plat_regs_pkg.sv
`timescale 1ns/1ps
package plat_regs_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned OFF_ID0     = 'h000;
  localparam int unsigned OFF_ID1     = 'h004;
  localparam int unsigned OFF_ID2     = 'h008;
  localparam int unsigned OFF_RSTCTL  = 'h010;
  localparam int unsigned OFF_MEMSTAT = 'h014;
  localparam int unsigned OFF_LINKSTA = 'h018;
  localparam int unsigned OFF_CLKDIV  = 'h030;
  localparam int unsigned OFF_BLDCFG  = 'h034;
  localparam int unsigned OFF_MEMCFG  = 'h038;
  localparam int unsigned RST_TRIG_BIT = 4;
  localparam int unsigned FULL_BYTES   = 4;

  // One bit per decoded register; at most one is set per cycle.
  typedef struct packed {
    logic ident;
    logic rstctl;
    logic memstat;
    logic linksta;
    logic clkdiv;
    logic bldcfg;
    logic memcfg;
  } reg_hit_t;

  function automatic logic [WORD_W-1:0] memstat_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[0] = 1'b1;
    w[2] = 1'b1;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] clkdiv_word(input int unsigned mhz);
    logic [7:0] f;
    f = mhz[7:0];
    return {8'd1, 8'd1, f, 8'd1};
  endfunction

  function automatic logic [WORD_W-1:0] bldcfg_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[3:1] = 3'b111;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] memcfg_word(input int unsigned gib);
    logic [3:0] g;
    g = gib[3:0];
    return {16'h0000, 12'hFFF, g};
  endfunction

endpackage

// File: rtl/plat_decode.sv
`timescale 1ns/1ps
module plat_decode
  import plat_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned BYTES_W = 4
) (
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTES_W-1:0] req_bytes,
  output logic               rd_fire,
  output logic               wr_full,
  output reg_hit_t           hit
);
  localparam logic [ADDR_W-1:0]  A_ID0     = ADDR_W'(OFF_ID0);
  localparam logic [ADDR_W-1:0]  A_ID1     = ADDR_W'(OFF_ID1);
  localparam logic [ADDR_W-1:0]  A_ID2     = ADDR_W'(OFF_ID2);
  localparam logic [ADDR_W-1:0]  A_RSTCTL  = ADDR_W'(OFF_RSTCTL);
  localparam logic [ADDR_W-1:0]  A_MEMSTAT = ADDR_W'(OFF_MEMSTAT);
  localparam logic [ADDR_W-1:0]  A_LINKSTA = ADDR_W'(OFF_LINKSTA);
  localparam logic [ADDR_W-1:0]  A_CLKDIV  = ADDR_W'(OFF_CLKDIV);
  localparam logic [ADDR_W-1:0]  A_BLDCFG  = ADDR_W'(OFF_BLDCFG);
  localparam logic [ADDR_W-1:0]  A_MEMCFG  = ADDR_W'(OFF_MEMCFG);
  localparam logic [BYTES_W-1:0] B_FULL    = BYTES_W'(FULL_BYTES);

  logic full_word;

  always_comb begin
    full_word = req_valid && (req_bytes == B_FULL);
    rd_fire   = req_valid && !req_write;
    wr_full   = full_word && req_write;
    hit       = '0;
    if (full_word) begin
      hit.ident   = (req_addr == A_ID0) || (req_addr == A_ID1) || (req_addr == A_ID2);
      hit.rstctl  = (req_addr == A_RSTCTL);
      hit.memstat = (req_addr == A_MEMSTAT);
      hit.linksta = (req_addr == A_LINKSTA);
      hit.clkdiv  = (req_addr == A_CLKDIV);
      hit.bldcfg  = (req_addr == A_BLDCFG);
      hit.memcfg  = (req_addr == A_MEMCFG);
    end
  end
endmodule

// File: rtl/plat_rdmux.sv
`timescale 1ns/1ps
module plat_rdmux
  import plat_regs_pkg::*;
#(
  parameter int unsigned MEM_GIB   = 2,
  parameter int unsigned TIMER_MHZ = 50
) (
  input  reg_hit_t            hit,
  output logic [WORD_W-1:0]   rd_word
);
  localparam logic [WORD_W-1:0] V_MEMSTAT = memstat_word();
  localparam logic [WORD_W-1:0] V_CLKDIV  = clkdiv_word(TIMER_MHZ);
  localparam logic [WORD_W-1:0] V_BLDCFG  = bldcfg_word();
  localparam logic [WORD_W-1:0] V_MEMCFG  = memcfg_word(MEM_GIB);

  // Identifier, reset-control and link-status words read as zero.
  always_comb begin
    rd_word = '0;
    if (hit.memstat) rd_word = V_MEMSTAT;
    if (hit.clkdiv)  rd_word = V_CLKDIV;
    if (hit.bldcfg)  rd_word = V_BLDCFG;
    if (hit.memcfg)  rd_word = V_MEMCFG;
  end
endmodule

// File: rtl/plat_rst_pulse.sv
`timescale 1ns/1ps
module plat_rst_pulse
  import plat_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_full,
  input  logic              hit_rstctl,
  input  logic [WORD_W-1:0] wdata,
  output logic              trig_now,
  output logic              pulse
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;
  assign trig_now     = wr_full && hit_rstctl && wdata[RST_TRIG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= trig_now;
  end
endmodule

// File: rtl/plat_status_regs.sv
`timescale 1ns/1ps
module plat_status_regs
  import plat_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MEM_GIB   = 2,
  parameter int unsigned TIMER_MHZ = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rdata,
  output logic              sys_reset_req
);
  reg_hit_t          hit;
  logic              rd_fire;
  logic              wr_full;
  logic              trig_now;
  logic [WORD_W-1:0] rd_word;

  plat_decode #(.ADDR_W(ADDR_W), .BYTES_W(4)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_bytes (req_bytes),
    .rd_fire   (rd_fire),
    .wr_full   (wr_full),
    .hit       (hit)
  );

  plat_rdmux #(.MEM_GIB(MEM_GIB), .TIMER_MHZ(TIMER_MHZ)) u_mux (
    .hit     (hit),
    .rd_word (rd_word)
  );

  plat_rst_pulse u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_full    (wr_full),
    .hit_rstctl (hit.rstctl),
    .wdata      (req_wdata),
    .trig_now   (trig_now),
    .pulse      (sys_reset_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_fire) rdata <= rd_word;
  end
endmodule

// File: rtl/plat_status_regs_chk.sv
`timescale 1ns/1ps
module plat_status_regs_chk
  import plat_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_bytes,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rdata,
  input logic              sys_reset_req,
  input reg_hit_t          hit
);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(OFF_RSTCTL);
  localparam logic [ADDR_W-1:0] A_MS  = ADDR_W'(OFF_MEMSTAT);
  localparam logic [ADDR_W-1:0] A_BC  = ADDR_W'(OFF_BLDCFG);

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R9

  AST_PARTIAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_bytes != 4'd4) |=> (rdata == 32'h0)); // R1

  AST_MEMSTAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_bytes == 4'd4 && req_addr == A_MS)
      |=> (rdata == 32'h0000_0005)); // R3

  AST_BLDCFG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_bytes == 4'd4 && req_addr == A_BC)
      |=> (rdata == 32'h0000_000E)); // R5

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_req) |-> $past(req_valid && req_write && req_bytes == 4'd4
                                   && req_addr == A_RST && req_wdata[4])); // R7

  AST_RST_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_bytes == 4'd4 && req_addr == A_RST && req_wdata[4])
      |=> sys_reset_req); // R7

  AST_NO_RST_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !sys_reset_req); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rdata)); // R10
endmodule

bind plat_status_regs plat_status_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/plat_status_regs_test.sv
`timescale 1ns/1ps
module plat_status_regs_test;
  localparam int GIB = 2;
  localparam int MHZ = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_bytes = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rdata;
  logic        sys_reset_req;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  plat_status_regs #(.ADDR_W(12), .MEM_GIB(GIB), .TIMER_MHZ(MHZ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rdata(rdata), .sys_reset_req(sys_reset_req)
  );

  function automatic logic [31:0] expect_word(input int a);
    case (a)
      'h014: return 32'd1 + 32'd4;
      'h030: return (32'd1 << 24) + (32'd1 << 16) + (32'(MHZ) << 8) + 32'd1;
      'h034: return 32'd2 + 32'd4 + 32'd8;
      'h038: return (32'd4095 << 4) + 32'(GIB);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input int a, input int sz, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'(a); req_bytes = 4'(sz);
    @(negedge clk);
    req_valid = 1'b0;
    d = rdata;
  endtask

  // Write, then report the reset request seen in the two following cycles.
  task automatic do_write(input int a, input int sz, input logic [31:0] w,
                          output logic p1, output logic p2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'(a); req_bytes = 4'(sz);
    req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0;
    p1 = sys_reset_req;
    @(negedge clk);
    p2 = sys_reset_req;
  endtask

  function automatic string tag_of(input int a);
    case (a)
      'h000, 'h004, 'h008: return "R2";
      'h014: return "R3";
      'h030: return "R4";
      'h034: return "R5";
      'h038: return "R6";
      default: return "R9";
    endcase
  endfunction

  initial begin
    logic [31:0] d;
    logic p1, p2;
    int sizes[6] = '{0, 1, 2, 3, 5, 8};
    repeat (3) @(negedge clk);
    check("R10 reset rdata", rdata, 32'h0);
    check("R10 reset pulse", {31'h0, sys_reset_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full-word read at every byte address.
    for (int a = 0; a < 4096; a++) begin
      do_read(a, 4, d);
      check(tag_of(a), d, expect_word(a));
    end

    // Hold after a nonzero read while idle.
    do_read('h030, 4, d);
    repeat (3) @(negedge clk);
    check("R10 hold", rdata, expect_word('h030));

    // Partial and oversize reads at every word offset.
    for (int a = 0; a < 4096; a += 4) begin
      for (int s = 0; s < 6; s++) begin
        do_read('h034, 4, d);
        do_read(a, sizes[s], d);
        check("R1 size read", d, 32'h0);
      end
    end

    // Reset trigger behaviour.
    do_write('h010, 4, 32'h0000_0010, p1, p2);
    check("R7 pulse high", {31'h0, p1}, 32'h1);
    check("R7 pulse one cycle", {31'h0, p2}, 32'h0);
    do_write('h010, 4, 32'hFFFF_FFEF, p1, p2);
    check("R7 bit4 clear", {31'h0, p1 | p2}, 32'h0);
    for (int s = 0; s < 6; s++) begin
      do_write('h010, sizes[s], 32'hFFFF_FFFF, p1, p2);
      check("R1 size write", {31'h0, p1 | p2}, 32'h0);
    end
    do_write('h011, 4, 32'hFFFF_FFFF, p1, p2);
    check("R9 unaligned trigger", {31'h0, p1 | p2}, 32'h0);

    // All-ones write to every other word offset, then read everything back.
    for (int a = 0; a < 4096; a += 4) begin
      if (a != 'h010) begin
        do_write(a, 4, 32'hFFFF_FFFF, p1, p2);
        check(a == 'h018 || a < 'h00C || (a >= 'h014 && a <= 'h038 && expect_word(a) != 0)
              ? "R8 ro write pulse" : "R9 write pulse", {31'h0, p1 | p2}, 32'h0);
      end
    end
    for (int a = 0; a < 4096; a += 4) begin
      do_read(a, 4, d);
      check(a == 'h018 || expect_word(a) != 0 || a < 'h00C ? "R8 readback" : "R9 readback",
            d, expect_word(a));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule